// File: doc/BRIEF.md
# Speculative History Undo Log

This block lets a core run memory operations past stores that have not yet completed while still looking sequentially consistent. Whenever at least one store is outstanding, every speculative change to a register or to an L1 data word is reported to the block together with the value it overwrote. The block keeps these old values in a log. Each entry is tagged with the epoch of the youngest store that was outstanding when the change was made. Cache writes also mark a small block-index table. An incoming coherence probe checks this table in the same cycle it arrives.

If a probe hits a block that is marked and still live, the block stalls the probe and replays the log backwards, newest entry first, presenting one old value per cycle. This returns state to the point of the oldest pending store. It then refuses new speculation until every outstanding store has completed. When stores complete in the normal way, log entries that belong to finished epochs retire from the oldest end and their table marks clear.

The controller has three states. In RUN the block logs and retires entries. In UNDO it replays the log. In DRAIN it blocks speculation. The transitions are:
- RUN→UNDO on a conflicting probe.
- UNDO→DRAIN when the last entry is replayed and stores remain outstanding.
- UNDO→RUN when the last entry is replayed and no stores remain.
- DRAIN→RUN when the outstanding-store count reaches zero.

Top module: `spec_undo_log`

## Requirements
- R1: After reset the log is empty, `log_stall`, `probe_stall` and `undo_valid` are low, and a probe causes no stall.
- R2: A log write made while no store is outstanding is not recorded.
- R3: During a rollback the recorded entries appear on the undo port newest first, one per cycle. Each entry carries its target flag (1 = cache, 0 = register), its address or register index, and its old value. Every recorded entry appears exactly once.
- R4: A probe conflicts only if `probe_idx` equals `log_addr[BLK_LSB +: IDXW]` (bits 5:2 by default) of a recorded cache write whose epoch is still live. Register entries never mark the table.
- R5: `probe_stall` is high from the cycle a conflicting probe arrives through the last undo cycle, which is N+1 cycles for N entries. It then drops with the table cleared.
- R6: After a rollback that leaves stores outstanding, `log_stall` stays high and log writes are dropped until the outstanding count reaches zero.
- R7: When the oldest pending store completes, entries older than the next pending store retire. Their blocks stop conflicting, and a later rollback replays only the newer entries.
- R8: With DEPTH entries held, `log_stall` is high and a further write is dropped.
- R9: A probe in the same cycle as the completion of the last pending store does not conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| log_valid | input | 1 | Speculative update to record |
| log_is_cache | input | 1 | 1 = L1 data word, 0 = register |
| log_addr | input | AW | Cache byte address or register index |
| log_old | input | DW | Value being overwritten |
| log_stall | output | 1 | Speculative updates must wait |
| st_issue | input | 1 | A store became outstanding |
| st_done | input | 1 | Oldest outstanding store completed |
| probe_valid | input | 1 | Coherence probe present |
| probe_idx | input | IDXW | Table index of the probed block |
| probe_stall | output | 1 | Probe held off |
| undo_valid | output | 1 | Restore entry presented |
| undo_is_cache | output | 1 | Restore target flag |
| undo_addr | output | AW | Restore address or register index |
| undo_data | output | DW | Value to write back |

## Verification
The hardest case to reach is retirement happening between two epochs. The probed block must belong to a store that completed, while the log still holds a newer epoch. The stimulus creates two outstanding stores and logs updates under each. It completes only the older store and waits for head retirement. It then probes the old block and expects no stall, and probes the new block and expects a replay that contains only the newer entries. A second hard case is a probe in the same cycle as the final store completion. It is produced by raising `st_done` and `probe_valid` in the same cycle.

// File: rtl/undo_pkg.sv
package undo_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_UNDO  = 2'd1,
        ST_DRAIN = 2'd2
    } undo_state_e;
endpackage

// File: rtl/undo_store.sv
module undo_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int EPW   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          push_cache,
    input  logic [AW-1:0]                 push_addr,
    input  logic [DW-1:0]                 push_data,
    input  logic [EPW-1:0]                push_tag,
    input  logic                          pop_new,
    input  logic                          pop_old,
    output logic                          new_cache,
    output logic [AW-1:0]                 new_addr,
    output logic [DW-1:0]                 new_data,
    output logic [EPW-1:0]                old_tag,
    output logic [$clog2(DEPTH):0]        cnt,
    output logic                          full,
    output logic                          empty
);
    localparam int PTRW = $clog2(DEPTH);
    localparam int CW   = PTRW + 1;

    logic            mem_cache [DEPTH];
    logic [AW-1:0]   mem_addr  [DEPTH];
    logic [DW-1:0]   mem_data  [DEPTH];
    logic [EPW-1:0]  mem_tag   [DEPTH];
    logic [PTRW-1:0] head_q, tail_q, newest;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (push) begin
            mem_cache[tail_q] <= push_cache;
            mem_addr[tail_q]  <= push_addr;
            mem_data[tail_q]  <= push_data;
            mem_tag[tail_q]   <= push_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            tail_q <= tail_q + PTRW'(push) - PTRW'(pop_new);
            head_q <= head_q + PTRW'(pop_old);
            cnt_q  <= cnt_q + CW'(push) - CW'(pop_new) - CW'(pop_old);
        end
    end

    always_comb begin
        newest    = tail_q - PTRW'(1);
        new_cache = mem_cache[newest];
        new_addr  = mem_addr[newest];
        new_data  = mem_data[newest];
        old_tag   = mem_tag[head_q];
        cnt       = cnt_q;
        full      = (cnt_q == CW'(DEPTH));
        empty     = (cnt_q == '0);
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_new || pop_old) |-> !empty);
endmodule

// File: rtl/undo_blt.sv
module undo_blt #(
    parameter int NBLK = 16,
    parameter int EPW  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mark,
    input  logic [$clog2(NBLK)-1:0]  mark_idx,
    input  logic [EPW-1:0]           mark_tag,
    input  logic                     clear_all,
    input  logic [EPW-1:0]           oldest_n,
    input  logic [EPW-1:0]           issue_n,
    input  logic [$clog2(NBLK)-1:0]  probe_idx,
    output logic                     hit
);
    localparam int IDXW = $clog2(NBLK);

    logic           vld [NBLK];
    logic [EPW-1:0] tag [NBLK];
    logic [EPW-1:0] span;

    assign span = issue_n - oldest_n;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [EPW-1:0] age;
        assign age = tag[g] - oldest_n;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
                tag[g] <= '0;
            end else if (clear_all) begin
                vld[g] <= 1'b0;
            end else if (mark && mark_idx == IDXW'(g)) begin
                vld[g] <= 1'b1;
                tag[g] <= mark_tag;
            end else if (age >= span) begin
                vld[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        hit = vld[probe_idx] && ((tag[probe_idx] - oldest_n) < span);
    end

    p_blt_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_all) |-> !hit);
endmodule

// File: rtl/undo_ctrl.sv
module undo_ctrl
    import undo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        probe_valid,
    input  logic        hit,
    input  logic        empty,
    input  logic        cnt_one,
    input  logic        pend_zero_n,
    output undo_state_e state,
    output logic        pop_new,
    output logic        clear_all,
    output logic        undo_valid,
    output logic        probe_stall,
    output logic        spec_hold
);
    undo_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:   if (probe_valid && hit) state_d = ST_UNDO;
            ST_UNDO:  if (empty || cnt_one)
                          state_d = pend_zero_n ? ST_RUN : ST_DRAIN;
            ST_DRAIN: if (pend_zero_n) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    always_comb begin
        pop_new     = 1'b0;
        clear_all   = 1'b0;
        undo_valid  = 1'b0;
        probe_stall = 1'b0;
        spec_hold   = 1'b1;
        unique case (state)
            ST_RUN: begin
                spec_hold   = 1'b0;
                probe_stall = probe_valid && hit;
            end
            ST_UNDO: begin
                pop_new     = !empty;
                undo_valid  = !empty;
                probe_stall = 1'b1;
                clear_all   = (state_d != ST_UNDO);
            end
            ST_DRAIN: ;
            default: ;
        endcase
    end

    p_conflict_enters_undo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && probe_valid && hit) |=> (state == ST_UNDO));
endmodule

// File: rtl/spec_undo_log.sv
module spec_undo_log
    import undo_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int EPW     = 4,
    parameter int NBLK    = 16,
    parameter int BLK_LSB = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     log_valid,
    input  logic                     log_is_cache,
    input  logic [AW-1:0]            log_addr,
    input  logic [DW-1:0]            log_old,
    output logic                     log_stall,
    input  logic                     st_issue,
    input  logic                     st_done,
    input  logic                     probe_valid,
    input  logic [$clog2(NBLK)-1:0]  probe_idx,
    output logic                     probe_stall,
    output logic                     undo_valid,
    output logic                     undo_is_cache,
    output logic [AW-1:0]            undo_addr,
    output logic [DW-1:0]            undo_data
);
    localparam int IDXW = $clog2(NBLK);
    localparam int CW   = $clog2(DEPTH) + 1;

    logic [EPW-1:0] issue_q, oldest_q, pend_q, issue_n, oldest_n, pend_n;
    logic [EPW-1:0] head_tag;
    logic [CW-1:0]  cnt;
    logic           push, retire, pop_new, clear_all, hit;
    logic           full, empty, spec_hold;
    undo_state_e    state;

    always_comb begin
        pend_q   = issue_q - oldest_q;
        issue_n  = issue_q + EPW'(st_issue);
        oldest_n = oldest_q + EPW'(st_done && pend_q != '0);
        pend_n   = issue_n - oldest_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_q  <= '0;
            oldest_q <= '0;
        end else begin
            issue_q  <= issue_n;
            oldest_q <= oldest_n;
        end
    end

    always_comb begin
        log_stall = spec_hold || full;
        push      = log_valid && !log_stall && (pend_q != '0);
        retire    = (state == ST_RUN) && !empty && ((head_tag - oldest_q) >= pend_q);
    end

    undo_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .EPW(EPW)) i_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_cache(log_is_cache), .push_addr(log_addr),
        .push_data(log_old), .push_tag(issue_q - EPW'(1)),
        .pop_new(pop_new), .pop_old(retire),
        .new_cache(undo_is_cache), .new_addr(undo_addr), .new_data(undo_data),
        .old_tag(head_tag), .cnt(cnt), .full(full), .empty(empty)
    );

    undo_blt #(.NBLK(NBLK), .EPW(EPW)) i_blt (
        .clk(clk), .rst_n(rst_n),
        .mark(push && log_is_cache), .mark_idx(log_addr[BLK_LSB +: IDXW]),
        .mark_tag(issue_q - EPW'(1)), .clear_all(clear_all),
        .oldest_n(oldest_n), .issue_n(issue_n),
        .probe_idx(probe_idx), .hit(hit)
    );

    undo_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .probe_valid(probe_valid), .hit(hit), .empty(empty),
        .cnt_one(cnt == CW'(1)), .pend_zero_n(pend_n == '0),
        .state(state), .pop_new(pop_new), .clear_all(clear_all),
        .undo_valid(undo_valid), .probe_stall(probe_stall), .spec_hold(spec_hold)
    );

    p_undo_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNDO && !empty) |=> (cnt == $past(cnt) - CW'(1)));
    p_undo_ends_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_UNDO && state != ST_UNDO) |-> empty);
    p_drain_has_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (pend_q != '0));
endmodule

// File: tb/test_spec_undo_log.sv
module test_spec_undo_log;
    typedef struct {
        logic        c;
        logic [15:0] a;
        logic [31:0] d;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        log_valid = 1'b0, log_is_cache = 1'b0;
    logic [15:0] log_addr = '0;
    logic [31:0] log_old = '0;
    logic        st_issue = 1'b0, st_done = 1'b0;
    logic        probe_valid = 1'b0;
    logic [3:0]  probe_idx = '0;
    logic        log_stall, probe_stall, undo_valid, undo_is_cache;
    logic [15:0] undo_addr;
    logic [31:0] undo_data;

    int n_chk = 0, n_fail = 0;
    ent_t logq[$];
    ent_t expq[$];

    spec_undo_log i_spec_undo_log (
        .clk(clk), .rst_n(rst_n),
        .log_valid(log_valid), .log_is_cache(log_is_cache), .log_addr(log_addr),
        .log_old(log_old), .log_stall(log_stall),
        .st_issue(st_issue), .st_done(st_done),
        .probe_valid(probe_valid), .probe_idx(probe_idx), .probe_stall(probe_stall),
        .undo_valid(undo_valid), .undo_is_cache(undo_is_cache),
        .undo_addr(undo_addr), .undo_data(undo_data)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && undo_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected undo item",
                      {15'd0, undo_is_cache, undo_addr, undo_data}, 64'd0);
            end else begin
                ent_t e;
                e = expq.pop_front();
                check({undo_is_cache, undo_addr, undo_data} == {e.c, e.a, e.d},
                      "R3 undo item order/content",
                      {15'd0, undo_is_cache, undo_addr, undo_data},
                      {15'd0, e.c, e.a, e.d});
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic log_wr(input logic c, input logic [15:0] a,
                          input logic [31:0] d, input bit keep);
        log_valid = 1'b1; log_is_cache = c; log_addr = a; log_old = d;
        tick();
        log_valid = 1'b0;
        if (keep) logq.push_back('{c: c, a: a, d: d});
    endtask

    task automatic issue();
        st_issue = 1'b1; tick(); st_issue = 1'b0;
    endtask

    task automatic done();
        st_done = 1'b1; tick(); st_done = 1'b0;
    endtask

    task automatic no_hit(input logic [3:0] idx, input string req);
        probe_valid = 1'b1; probe_idx = idx;
        #1;
        check(probe_stall == 1'b0, req, {63'd0, probe_stall}, 64'd0);
        probe_valid = 1'b0;
    endtask

    task automatic rollback(input logic [3:0] idx, input int n_exp);
        int n;
        expq.delete();
        for (int k = logq.size() - 1; k >= 0; k--) expq.push_back(logq[k]);
        logq.delete();
        probe_valid = 1'b1; probe_idx = idx;
        #1;
        n = 0;
        while (probe_stall && n < 40) begin
            n++;
            tick();
        end
        probe_valid = 1'b0;
        check(n == n_exp + 1, "R5 probe_stall length", 64'(n), 64'(n_exp + 1));
        check(expq.size() == 0, "R3 every entry replayed", 64'(expq.size()), 64'd0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(log_stall == 1'b0, "R1 log_stall after reset", {63'd0, log_stall}, 64'd0);
        check(undo_valid == 1'b0, "R1 undo_valid after reset", {63'd0, undo_valid}, 64'd0);
        check(probe_stall == 1'b0, "R1 probe_stall after reset", {63'd0, probe_stall}, 64'd0);
        no_hit(4'd9, "R1 probe after reset");

        // R2 write with no pending store is dropped
        log_wr(1'b1, 16'h0100, 32'hAAAA_0001, 1'b0);
        issue();
        log_wr(1'b0, 16'h0005, 32'h1111_2222, 1'b1);
        log_wr(1'b1, 16'h0024, 32'h3333_4444, 1'b1);
        log_wr(1'b1, 16'h0026, 32'h5555_6666, 1'b1);
        no_hit(4'd0, "R2 dropped write leaves block unmarked");
        no_hit(4'd1, "R4 register entry does not mark table");
        no_hit(4'd12, "R4 untouched block");
        rollback(4'd9, 3);
        // R6 drain
        check(log_stall == 1'b1, "R6 log_stall after rollback", {63'd0, log_stall}, 64'd1);
        log_wr(1'b1, 16'h0024, 32'h0000_0BAD, 1'b0);
        done();
        check(log_stall == 1'b0, "R6 log_stall released", {63'd0, log_stall}, 64'd0);
        issue();
        log_wr(1'b1, 16'h0024, 32'h0000_0001, 1'b1);
        rollback(4'd9, 1);
        done();

        // R7 retirement between epochs
        issue();
        log_wr(1'b1, 16'h0040, 32'hC0DE_0000, 1'b1);
        issue();
        log_wr(1'b1, 16'h0048, 32'hC0DE_0001, 1'b1);
        log_wr(1'b0, 16'h000C, 32'hC0DE_0002, 1'b1);
        done();
        repeat (3) tick();
        void'(logq.pop_front());
        no_hit(4'd0, "R7 retired block no longer conflicts");
        rollback(4'd2, 2);
        done();
        repeat (2) tick();

        // R9 probe with final completion
        issue();
        log_wr(1'b1, 16'h0010, 32'hFEED_0000, 1'b1);
        st_done = 1'b1; probe_valid = 1'b1; probe_idx = 4'd4;
        #1;
        check(probe_stall == 1'b0, "R9 same-cycle completion no conflict",
              {63'd0, probe_stall}, 64'd0);
        tick();
        st_done = 1'b0; probe_valid = 1'b0;
        repeat (3) tick();
        logq.delete();
        no_hit(4'd4, "R9 block clear after completion");

        // R8 full
        issue();
        for (int i = 0; i < 8; i++)
            log_wr(1'b1, 16'(i * 4), 32'hF000_0000 + 32'(i), 1'b1);
        check(log_stall == 1'b1, "R8 log_stall when full", {63'd0, log_stall}, 64'd1);
        log_wr(1'b1, 16'h0020, 32'hDEAD_DEAD, 1'b0);
        rollback(4'd0, 8);
        done();
        tick();
        check(log_stall == 1'b0, "R6 free after final drain", {63'd0, log_stall}, 64'd0);

        repeat (3) tick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule